// File: doc/BRIEF.md
# Scatter-gather descriptor walker

This block follows a chain of 16-byte descriptors in memory and turns each one into a single transfer request for a separate data mover. A descriptor is read as four little-endian 32-bit words. Word 0 holds the buffer address. Word 1 holds the length counted in 8-byte units. Word 2 packs a flags byte, a mode byte, a packet-length byte and a spare byte. Word 3 holds the address of the following descriptor. The walker does not move data itself. It reads descriptors through a single-outstanding 32-bit read port and hands the decoded fields to the mover over a request/acknowledge pair.

A walk begins with a one-cycle start pulse that carries the head pointer. The walker fetches one descriptor, checks it, and presents the request. It then waits for the acknowledge before it touches memory again. The walk ends with a one-cycle done pulse after the acknowledge of the descriptor marked last. If the chain is malformed, the walk ends instead with a one-cycle error pulse and a 2-bit reason code. No request is issued for the faulty descriptor. The only address arithmetic the walker performs is to check that a buffer does not run past the top of the 32-bit address space.

Top module: `sgw_walker`

## Requirements
- R1: After reset, and whenever busy is low, rd_req and xfer_req are low. After reset, done and err are low. Reset taken in the middle of a walk returns the block to idle on the next cycle.
- R2: A descriptor at address P is read as four words at P, P+4, P+8 and P+12, in that order. Only one read is outstanding at a time, and rd_addr stays steady until rd_rvalid is seen.
- R3: xfer_addr equals word 0. xfer_bytes equals word 1 multiplied by 8. xfer_ordered is word 2 bit 4. xfer_dir_out is word 2 bit 5. xfer_mode is word 2 bits 11:8. Word 2 bits 3:0, bit 6 and bits 31:12 have no effect.
- R4: xfer_req stays high, with every field steady, until xfer_ack is sampled high. No read is issued while xfer_req is high. Each valid descriptor produces exactly one request.
- R5: When word 2 bit 7 is clear, the next descriptor is fetched from the address in word 3. When bit 7 is set, done pulses for one cycle on the cycle after that descriptor's acknowledge, and busy is low on that cycle.
- R6: err pulses for one cycle with a reason code. Code 1 means the head pointer, or a nonzero word 3, has any of its low three bits set. Code 2 means word 3 is zero while bit 7 is clear. Code 3 means the buffer address plus the byte count exceeds 2^32. A misaligned head pointer causes no read. err_code holds its value until the next accepted start, which resets it to 0.
- R7: When one descriptor has several faults, code 3 wins over code 1, and code 1 wins over code 2.
- R8: A buffer that ends exactly at 2^32 is accepted and transferred.
- R9: A start pulse that arrives while busy is high is ignored. The walk in progress completes unchanged.
- R10: A descriptor with a length of zero still issues one request, with a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| head_ptr | input | ADDR_W | Address of the first descriptor, sampled with start |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: the last descriptor was acknowledged |
| err | output | 1 | One-cycle pulse: the walk was aborted |
| err_code | output | 2 | Abort reason: 0 none, 1 misaligned pointer, 2 broken chain, 3 address wrap |
| rd_req | output | 1 | Read request, held until rd_rvalid |
| rd_addr | output | ADDR_W | Byte address of the word being read |
| rd_rvalid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | ADDR_W | Buffer start address |
| xfer_bytes | output | LEN_W+3 | Transfer size in bytes |
| xfer_dir_out | output | 1 | 1: toward the device |
| xfer_ordered | output | 1 | Ordered-transfer flag |
| xfer_mode | output | MODE_W | Per-descriptor transfer mode |
| xfer_ack | input | 1 | Data mover accepts the request |

## Verification
The hardest states to reach from the ports are a descriptor that carries two faults at once, which is needed for the priority rule, and a start pulse that lands inside a walk that is still running. The bench builds its descriptor chains in a model memory and can deliberately corrupt the address, the length, the flags or the pointer of one chosen entry. It also stretches both the read response and the acknowledge over several cycles. That keeps the walker busy long enough to inject a second start, or a reset, at a known point in the walk.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;

   // Descriptor geometry and flag positions (word 2, byte 0).
   localparam int SGW_WORDS  = 4;
   localparam int SGW_WORD_W = 32;
   localparam int SGW_F_ORD  = 4;
   localparam int SGW_F_OUT  = 5;
   localparam int SGW_F_LAST = 7;
   localparam int SGW_MODE_LSB = 8;

   typedef enum logic [1:0] {
      SGW_OK        = 2'd0,
      SGW_ERR_ALIGN = 2'd1,
      SGW_ERR_CHAIN = 2'd2,
      SGW_ERR_WRAP  = 2'd3
   } sgw_err_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_CHECK = 2'd2,
      ST_ISSUE = 2'd3
   } sgw_state_e;

endpackage

// File: rtl/sgw_fetch.sv
`timescale 1ns/1ps
module sgw_fetch #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    kick,
   input  logic [ADDR_W-1:0]       base,
   output logic                    rd_req,
   output logic [ADDR_W-1:0]       rd_addr,
   input  logic                    rd_rvalid,
   input  logic [WORD_W-1:0]       rd_data,
   output logic [WORDS*WORD_W-1:0] words,
   output logic                    fin
);

   localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int STRIDE = WORD_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("sgw_fetch: WORD_W must be a whole number of bytes");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("sgw_fetch: WORDS must be at least 2");
   end

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_req  <= 1'b0;
         rd_addr <= '0;
         idx     <= '0;
         words   <= '0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (kick) begin
            rd_req  <= 1'b1;
            rd_addr <= base;
            idx     <= '0;
         end else if (rd_req && rd_rvalid) begin
            words[int'(idx)*WORD_W +: WORD_W] <= rd_data;
            if (idx == IDX_W'(WORDS-1)) begin
               rd_req <= 1'b0;
               fin    <= 1'b1;
            end else begin
               idx     <= idx + 1'b1;
               rd_addr <= rd_addr + ADDR_W'(STRIDE);
            end
         end
      end
   end

endmodule

// File: rtl/sgw_decode.sv
`timescale 1ns/1ps
module sgw_decode
   import sgw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 32,
   parameter int MODE_W     = 4,
   parameter int ALIGN_BITS = 3,
   parameter bit CHECK_WRAP = 1'b1,
   localparam int BYTES_W   = LEN_W + 3,
   localparam int ENTRY_W   = SGW_WORDS * SGW_WORD_W
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic [ADDR_W-1:0]  buf_addr,
   output logic [BYTES_W-1:0] bytes,
   output logic               dir_out,
   output logic               ordered,
   output logic               last,
   output logic [MODE_W-1:0]  mode,
   output logic [ADDR_W-1:0]  next_ptr,
   output sgw_err_e           fault
);

   localparam int W2 = 2 * SGW_WORD_W;
   localparam int W3 = 3 * SGW_WORD_W;

   if (MODE_W < 1 || MODE_W > 8) begin : g_bad_mode
      $error("sgw_decode: MODE_W must lie in 1..8");
   end

   logic wrap;
   logic misaligned;
   logic broken;

   assign buf_addr = entry[0 +: ADDR_W];
   assign bytes    = {entry[SGW_WORD_W +: LEN_W], 3'b000};
   assign ordered  = entry[W2 + SGW_F_ORD];
   assign dir_out  = entry[W2 + SGW_F_OUT];
   assign last     = entry[W2 + SGW_F_LAST];
   assign mode     = entry[W2 + SGW_MODE_LSB +: MODE_W];
   assign next_ptr = entry[W3 +: ADDR_W];

   // Bits with no meaning to the walker (spare flags, upper mode bits, packet length).
   logic unused_bits;
   assign unused_bits = ^{entry[W2 +: 4], entry[W2 + 6], entry[W3-1 : W2 + SGW_MODE_LSB + MODE_W]};

   if (CHECK_WRAP) begin : g_wrap
      localparam int SUM_W = BYTES_W + 1;
      logic [SUM_W-1:0] span_end;
      assign span_end = SUM_W'(buf_addr) + SUM_W'(bytes);
      assign wrap     = span_end > (SUM_W'(1) << ADDR_W);
   end else begin : g_nowrap
      assign wrap = 1'b0;
   end

   assign misaligned = (next_ptr != '0) && (next_ptr[ALIGN_BITS-1:0] != '0);
   assign broken     = !last && (next_ptr == '0);

   always_comb begin
      if (wrap)            fault = SGW_ERR_WRAP;
      else if (misaligned) fault = SGW_ERR_ALIGN;
      else if (broken)     fault = SGW_ERR_CHAIN;
      else                 fault = SGW_OK;
   end

endmodule

// File: rtl/sgw_walker.sv
`timescale 1ns/1ps
module sgw_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 32,
   parameter int MODE_W     = 4,
   parameter int ALIGN_BITS = 3,
   parameter bit CHECK_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] head_ptr,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [1:0]        err_code,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rvalid,
   input  logic [31:0]       rd_data,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [LEN_W+2:0]  xfer_bytes,
   output logic              xfer_dir_out,
   output logic              xfer_ordered,
   output logic [MODE_W-1:0] xfer_mode,
   input  logic              xfer_ack
);

   localparam int BYTES_W = LEN_W + 3;
   localparam int ENTRY_W = SGW_WORDS * SGW_WORD_W;

   if (ADDR_W < 8 || ADDR_W > SGW_WORD_W) begin : g_bad_addr
      $error("sgw_walker: ADDR_W must lie in 8..32");
   end
   if (LEN_W < 1 || LEN_W > SGW_WORD_W) begin : g_bad_len
      $error("sgw_walker: LEN_W must lie in 1..32");
   end
   if (CHECK_WRAP && (BYTES_W < ADDR_W)) begin : g_bad_span
      $error("sgw_walker: byte count narrower than the address");
   end
   if (ALIGN_BITS < 2 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("sgw_walker: ALIGN_BITS must cover word alignment");
   end

   sgw_state_e         st;
   sgw_err_e           err_q;
   logic [ADDR_W-1:0]  next_q;
   logic               last_q;
   logic               head_ok;
   logic               kick;
   logic [ADDR_W-1:0]  kick_base;
   logic [ENTRY_W-1:0] entry;
   logic               fetch_fin;

   logic [ADDR_W-1:0]  d_addr;
   logic [BYTES_W-1:0] d_bytes;
   logic               d_dir;
   logic               d_ord;
   logic               d_last;
   logic [MODE_W-1:0]  d_mode;
   logic [ADDR_W-1:0]  d_next;
   sgw_err_e           d_fault;

   assign head_ok   = (head_ptr[ALIGN_BITS-1:0] == '0);
   assign kick      = ((st == ST_IDLE) && start && head_ok) ||
                      ((st == ST_ISSUE) && xfer_ack && !last_q);
   assign kick_base = (st == ST_IDLE) ? head_ptr : next_q;
   assign busy      = (st != ST_IDLE);
   assign err_code  = err_q;

   sgw_fetch #(
      .ADDR_W (ADDR_W),
      .WORD_W (SGW_WORD_W),
      .WORDS  (SGW_WORDS)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick      (kick),
      .base      (kick_base),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_rvalid (rd_rvalid),
      .rd_data   (rd_data),
      .words     (entry),
      .fin       (fetch_fin)
   );

   sgw_decode #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .MODE_W     (MODE_W),
      .ALIGN_BITS (ALIGN_BITS),
      .CHECK_WRAP (CHECK_WRAP)
   ) u_decode (
      .entry    (entry),
      .buf_addr (d_addr),
      .bytes    (d_bytes),
      .dir_out  (d_dir),
      .ordered  (d_ord),
      .last     (d_last),
      .mode     (d_mode),
      .next_ptr (d_next),
      .fault    (d_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         err_q        <= SGW_OK;
         next_q       <= '0;
         last_q       <= 1'b0;
         done         <= 1'b0;
         err          <= 1'b0;
         xfer_req     <= 1'b0;
         xfer_addr    <= '0;
         xfer_bytes   <= '0;
         xfer_dir_out <= 1'b0;
         xfer_ordered <= 1'b0;
         xfer_mode    <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  err_q <= SGW_OK;
                  if (head_ok) begin
                     st <= ST_FETCH;
                  end else begin
                     err   <= 1'b1;
                     err_q <= SGW_ERR_ALIGN;
                  end
               end
            end
            ST_FETCH: begin
               if (fetch_fin) st <= ST_CHECK;
            end
            ST_CHECK: begin
               if (d_fault != SGW_OK) begin
                  err   <= 1'b1;
                  err_q <= d_fault;
                  st    <= ST_IDLE;
               end else begin
                  xfer_req     <= 1'b1;
                  xfer_addr    <= d_addr;
                  xfer_bytes   <= d_bytes;
                  xfer_dir_out <= d_dir;
                  xfer_ordered <= d_ord;
                  xfer_mode    <= d_mode;
                  last_q       <= d_last;
                  next_q       <= d_next;
                  st           <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (xfer_ack) begin
                  xfer_req <= 1'b0;
                  if (last_q) begin
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end else begin
                     st <= ST_FETCH;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sgw_walker_chk.sv
`timescale 1ns/1ps
module sgw_walker_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 32,
   parameter int MODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [1:0]        err_code,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_rvalid,
   input logic              xfer_req,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [LEN_W+2:0]  xfer_bytes,
   input logic              xfer_dir_out,
   input logic              xfer_ordered,
   input logic [MODE_W-1:0] xfer_mode,
   input logic              xfer_ack
);

   p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !xfer_req));

   p_read_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_rvalid) |=> (rd_req && $stable(rd_addr)));

   p_read_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[1:0] == 2'b00));

   p_bytes_whole_units_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (xfer_bytes[2:0] == 3'b000));

   p_request_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_bytes)
         && $stable(xfer_dir_out) && $stable(xfer_ordered) && $stable(xfer_mode)));

   p_no_read_during_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !rd_req);

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_at_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !err));

   p_err_has_reason_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (err_code != 2'd0 && !busy));

   p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

endmodule

bind sgw_walker sgw_walker_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .MODE_W (MODE_W)
) u_sgw_walker_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .err          (err),
   .err_code     (err_code),
   .rd_req       (rd_req),
   .rd_addr      (rd_addr),
   .rd_rvalid    (rd_rvalid),
   .xfer_req     (xfer_req),
   .xfer_addr    (xfer_addr),
   .xfer_bytes   (xfer_bytes),
   .xfer_dir_out (xfer_dir_out),
   .xfer_ordered (xfer_ordered),
   .xfer_mode    (xfer_mode),
   .xfer_ack     (xfer_ack)
);

// File: tb/test_sgw_walker.sv
`timescale 1ns/1ps
module test_sgw_walker;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [31:0] head_in;
   logic        busy, done, err;
   logic [1:0]  err_code;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_rvalid;
   logic [31:0] rd_data;
   logic        xfer_req;
   logic [31:0] xfer_addr;
   logic [34:0] xfer_bytes;
   logic        xfer_dir_out, xfer_ordered;
   logic [3:0]  xfer_mode;
   logic        xfer_ack;

   always #2 clk = ~clk;

   sgw_walker i_sgw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_in),
      .busy(busy), .done(done), .err(err), .err_code(err_code),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_data(rd_data),
      .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
      .xfer_dir_out(xfer_dir_out), .xfer_ordered(xfer_ordered),
      .xfer_mode(xfer_mode), .xfer_ack(xfer_ack)
   );

   int checks = 0;
   int fails  = 0;

   logic [31:0] mem [0:255];
   int          lat_g = 0;
   int          rd_n = 0;
   logic [31:0] rd_log [0:63];
   int          got_n = 0;
   logic [72:0] got [0:15];
   int          done_n = 0;
   int          err_n = 0;
   logic [1:0]  code_seen = 2'd0;
   logic [72:0] ex_rec [0:3];
   int          exp_n = 0;
   int          exp_fetch = 0;

   typedef struct packed {
      logic [9:0] head;
      logic [1:0] nm1;
      logic [7:0] len;
      logic [3:0] mode;
      logic       dir;
      logic       ord;
      logic [1:0] lat;
      logic [2:0] cor;
      logic [1:0] code;
   } vec_t;

   // cor: 0 clean, 1 misaligned next on entry 0, 2 last entry loses end flag,
   //      3 last entry wraps, 4 last entry ends exactly at 2^32, 5 entry 0 wraps and misaligned next
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{10'h040, 2'd0, 8'h10, 4'h2, 1'b0, 1'b1, 2'd0, 3'd0, 2'd0},
      '{10'h100, 2'd2, 8'h01, 4'h4, 1'b1, 1'b0, 2'd1, 3'd0, 2'd0},
      '{10'h200, 2'd3, 8'hFF, 4'hF, 1'b1, 1'b1, 2'd2, 3'd0, 2'd0},
      '{10'h080, 2'd1, 8'h00, 4'h0, 1'b0, 1'b0, 2'd3, 3'd0, 2'd0},
      '{10'h180, 2'd1, 8'h03, 4'h1, 1'b0, 1'b1, 2'd1, 3'd1, 2'd1},
      '{10'h240, 2'd2, 8'h07, 4'h6, 1'b1, 1'b0, 2'd0, 3'd2, 2'd2},
      '{10'h2C0, 2'd1, 8'h05, 4'h3, 1'b1, 1'b1, 2'd2, 3'd3, 2'd3},
      '{10'h300, 2'd1, 8'h09, 4'h9, 1'b0, 1'b0, 2'd1, 3'd4, 2'd0},
      '{10'h360, 2'd1, 8'h02, 4'h5, 1'b0, 1'b1, 2'd0, 3'd5, 2'd3}
   };

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // Memory read responder
   initial begin
      int w = 0;
      rd_rvalid = 1'b0;
      rd_data   = '0;
      forever begin
         @(negedge clk);
         if (rd_req && rst_n) begin
            if (w >= lat_g) begin
               rd_rvalid = 1'b1;
               rd_data   = mem[rd_addr[9:2]];
               if (rd_n < 64) rd_log[rd_n] = rd_addr;
               rd_n++;
               w = 0;
            end else begin
               rd_rvalid = 1'b0;
               w++;
            end
         end else begin
            rd_rvalid = 1'b0;
            w = 0;
         end
      end
   end

   // Data mover responder
   initial begin
      int w = 0;
      xfer_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (xfer_req && rst_n) begin
            if (w >= lat_g) begin
               xfer_ack = 1'b1;
               if (got_n < 16) got[got_n] = {xfer_addr, xfer_bytes, xfer_dir_out, xfer_ordered, xfer_mode};
               got_n++;
               w = 0;
            end else begin
               xfer_ack = 1'b0;
               w++;
            end
         end else begin
            xfer_ack = 1'b0;
            w = 0;
         end
      end
   end

   // Pulse monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done) done_n++;
         if (err) begin
            err_n++;
            code_seen = err_code;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   task automatic build(input vec_t v, input int vi);
      int n;
      n = int'(v.nm1) + 1;
      for (int k = 0; k < n; k++) begin
         logic [31:0] a, ln, nx, base;
         logic        lst;
         logic [7:0]  fl;
         int          ix;
         base = 32'(v.head) + 32'(k * 32);
         a    = 32'h1000_0000 + 32'(vi * 32'h1000) + 32'(k * 32'h100);
         ln   = 32'(v.len) + 32'(k);
         if (k == n-1 && v.cor == 3'd3) begin a = 32'hFFFF_FF00; ln = 32'h21; end
         if (k == n-1 && v.cor == 3'd4) begin a = 32'hFFFF_FF00; ln = 32'h20; end
         if (k == 0   && v.cor == 3'd5) begin a = 32'hFFFF_FFF8; ln = 32'h2;  end
         lst = (k == n-1) && (v.cor != 3'd2);
         nx  = (k == n-1) ? 32'h0 : base + 32'd32;
         if (k == 0 && v.cor == 3'd1) nx = base + 32'd36;
         if (k == 0 && v.cor == 3'd5) nx = base + 32'd34;
         fl = {lst, 1'b1, v.dir, v.ord, 4'b1010};
         ix = int'(base[9:2]);
         mem[ix]   = a;
         mem[ix+1] = ln;
         mem[ix+2] = {8'hA5, 8'h5A, 4'hC, v.mode, fl};
         mem[ix+3] = nx;
         if (k < 4) ex_rec[k] = {a, ln, 3'b000, v.dir, v.ord, v.mode};
      end
      case (v.cor)
         3'd0, 3'd4: begin exp_n = n;     exp_fetch = n; end
         3'd1, 3'd5: begin exp_n = 0;     exp_fetch = 1; end
         default:    begin exp_n = n - 1; exp_fetch = n; end
      endcase
   endtask

   task automatic run_walk(input logic [31:0] head, input int lat,
                           output int dn, output int en, output bit hung);
      int d0, e0, cnt;
      lat_g = lat;
      got_n = 0;
      rd_n  = 0;
      d0 = done_n;
      e0 = err_n;
      @(negedge clk);
      start = 1'b1;
      head_in = head;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (done_n == d0 && err_n == e0 && cnt < 4000) begin
         @(negedge clk);
         cnt++;
      end
      repeat (3) @(negedge clk);
      dn = done_n - d0;
      en = err_n - e0;
      hung = (cnt >= 4000);
   endtask

   initial begin
      int  dn, en;
      bit  hung;
      vec_t d;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      rst_n = 1'b0;
      start = 1'b0;
      head_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, err, rd_req, xfer_req} == 5'b0, "R1", "reset state",
            80'({busy, done, err, rd_req, xfer_req}), 80'h0);

      // Table of chains
      for (int vi = 0; vi < NV; vi++) begin
         string tg;
         bit    seq_ok;
         build(VEC[vi], vi);
         run_walk(32'(VEC[vi].head), int'(VEC[vi].lat), dn, en, hung);
         tg = (VEC[vi].cor == 3'd5) ? "R7" : (VEC[vi].cor == 3'd4) ? "R8" :
              (VEC[vi].cor != 3'd0) ? "R6" : "R5";
         if (VEC[vi].code == 2'd0) begin
            check(!hung && dn == 1 && en == 0, tg, $sformatf("vec %0d completes", vi),
                  80'({dn[7:0], en[7:0]}), 80'h0100);
         end else begin
            check(!hung && dn == 0 && en == 1 && code_seen == VEC[vi].code, tg,
                  $sformatf("vec %0d abort code", vi),
                  80'({dn[7:0], en[7:0], 6'b0, code_seen}), 80'({8'd0, 8'd1, 6'b0, VEC[vi].code}));
         end
         check(got_n == exp_n, "R4", $sformatf("vec %0d request count", vi),
               80'(got_n), 80'(exp_n));
         for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(got[k] == ex_rec[k], (vi == 3) ? "R10" : "R3",
                  $sformatf("vec %0d request %0d fields", vi, k), 80'(got[k]), 80'(ex_rec[k]));
         end
         seq_ok = (rd_n == 4 * exp_fetch);
         for (int j = 0; j < 4; j++)
            if (rd_log[j] != 32'(VEC[vi].head) + 32'(4 * j)) seq_ok = 1'b0;
         check(seq_ok, "R2", $sformatf("vec %0d read sequence", vi),
               80'({rd_n[15:0], rd_log[0]}), 80'({16'(4 * exp_fetch), 32'(VEC[vi].head)}));
      end

      // Misaligned head pointer: abort without any read, code held afterwards
      run_walk(32'h0000_0044, 0, dn, en, hung);
      check(en == 1 && code_seen == 2'd1, "R6", "misaligned head code",
            80'({en[7:0], 6'b0, code_seen}), 80'h0101);
      check(rd_n == 0, "R6", "misaligned head issues no read", 80'(rd_n), 80'h0);
      repeat (10) @(negedge clk);
      check(err_code == 2'd1 && !err, "R6", "code held after abort",
            80'({err, err_code}), 80'h1);

      // Start while busy is ignored; accepted start clears the code
      d = '{10'h040, 2'd1, 8'h11, 4'h7, 1'b1, 1'b0, 2'd3, 3'd0, 2'd0};
      build(d, 20);
      lat_g = 3;
      got_n = 0;
      dn = done_n;
      en = err_n;
      @(negedge clk);
      start = 1'b1;
      head_in = 32'h0000_0040;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      check(busy == 1'b1, "R9", "busy before second start", 80'(busy), 80'h1);
      start = 1'b1;
      head_in = 32'h0000_0100;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 2000 && done_n == dn && err_n == en; c++) @(negedge clk);
      repeat (40) @(negedge clk);
      check(done_n - dn == 1 && err_n == en && got_n == 2, "R9", "walk unaffected by second start",
            80'({8'(done_n - dn), 8'(got_n)}), 80'h0102);
      check(got[0] == ex_rec[0] && got[1] == ex_rec[1], "R9", "requests from first chain",
            80'(got[1]), 80'(ex_rec[1]));
      check(!busy && err_code == 2'd0, "R6", "code cleared by accepted start",
            80'({busy, err_code}), 80'h0);

      // Reset in the middle of a walk
      build(d, 21);
      lat_g = 3;
      @(negedge clk);
      start = 1'b1;
      head_in = 32'h0000_0040;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 200 && !xfer_req; c++) @(negedge clk);
      check(xfer_req == 1'b1, "R4", "request raised before reset", 80'(xfer_req), 80'h1);
      rst_n = 1'b0;
      @(negedge clk);
      check({busy, rd_req, xfer_req, done, err} == 5'b0, "R1", "idle after reset mid-walk",
            80'({busy, rd_req, xfer_req, done, err}), 80'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule